// File: doc/BRIEF.md
# Banked Program Address Mapper

This block sits between a CPU and a program memory of power-of-two size. It turns each CPU address in the upper 32 KB into a physical program-memory address. The CPU side is split into four 8 KB windows. The first three windows take their bank numbers from three bank registers. A swap flag rotates which register feeds which window. The top window always shows the last 8 KB bank.

Software programs the mapper by writing into the 0x8000–0xFFFF range. Address bit 0 picks between the even and odd register of each 8 KB region:

- An even write in the lowest region loads a selector index and the swap flag.
- An odd write in the same region stores the data into the register that the index names.
- An even write in the second region sets the nametable mirroring output. A four-screen strap input locks this output.
- Every other write in the range belongs to neighbouring blocks and is ignored here.

Top module: `prg_bank_mapper`

## Requirements
- R1: After synchronous reset, windows 0x8000, 0xA000, 0xC000 and 0xE000 map to banks N-4, N-3, N-2 and N-1 in that order, where N is the number of 8 KB banks. The mirroring output reads 0 (vertical).
- R2: Writes to addresses below 0x8000, and cycles with `cpu_wr` low, change no mapping and no mirroring state.
- R3: An even write to 0x8000–0x9FFF latches data bits 3:0 as the selector index and data bit 6 as the swap flag. Data bits 7, 5 and 4 have no effect on the mapping.
- R4: An odd write to 0x8000–0x9FFF stores the data byte into bank register A when the index is 6, into B when it is 7, and into C when it is 15.
- R5: An odd write to 0x8000–0x9FFF with any other index leaves A, B and C unchanged.
- R6: With the swap flag at 0, the windows 0x8000, 0xA000 and 0xC000 use A, B and C respectively.
- R7: With the swap flag at 1, the windows 0x8000, 0xA000 and 0xC000 use C, A and B respectively.
- R8: Window 0xE000–0xFFFF always maps to bank N-1, whatever the registers hold.
- R9: A bank number wraps modulo N. The physical address is (bank mod N)·8192 + CPU address bits 12:0.
- R10: An even write to 0xA000–0xBFFF sets `mirror_horiz` to data bit 0, where 1 means horizontal and 0 means vertical.
- R11: While `four_screen` is high, writes to the mirroring register do not change `mirror_horiz`.
- R12: Odd writes in 0xA000–0xFFFF and even writes in 0xC000–0xFFFF change no mapping and no mirroring state.
- R13: Register writes take effect at the clock edge that samples `cpu_wr`. The translation is combinational from the registers. Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| four_screen | input | 1 | Strap that locks the mirroring output |
| phys_addr | output | PRG_AW | Physical program-memory address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
Two functions of the block can fall in the same cycle.

The first pair is a bank-register write and a lookup through the window that this register feeds. The bench writes 0x8001 while the swap flag is 0, so the write address itself lies in the window it reprograms. It checks that `phys_addr` shows the old bank before the edge and the new bank after it.

The second pair is reset and a register write. The bench asserts `rst` together with a write strobe that would otherwise load a bank. It checks that the reset mapping is what appears after the edge.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int PRG_AW = 17,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic              four_screen,
  output logic [PRG_AW-1:0] phys_addr,
  output logic              mirror_horiz
);
  localparam int NB_W   = PRG_AW - 13;
  localparam int NBANKS = 1 << NB_W;

  logic [3:0]        sel_idx;
  logic              swap_q;
  logic [BANK_W-1:0] bank_a, bank_b, bank_c;
  logic              mirror_q;
  logic [NB_W-1:0]   win_bank;

  wire       in_space = cpu_wr && cpu_addr[15];
  wire [2:0] wr_kind  = {cpu_addr[14:13], cpu_addr[0]};

  wire unused_ok = ^{1'b0, cpu_data[7], cpu_data[5:4], bank_a, bank_b, bank_c};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx  <= '0;
      swap_q   <= 1'b0;
      bank_a   <= BANK_W'(NBANKS - 4);
      bank_b   <= BANK_W'(NBANKS - 3);
      bank_c   <= BANK_W'(NBANKS - 2);
      mirror_q <= 1'b0;
    end else if (in_space) begin
      case (wr_kind)
        3'b000: begin
          sel_idx <= cpu_data[3:0];
          swap_q  <= cpu_data[6];
        end
        3'b001: begin
          case (sel_idx)
            4'd6:    bank_a <= cpu_data[BANK_W-1:0];
            4'd7:    bank_b <= cpu_data[BANK_W-1:0];
            4'd15:   bank_c <= cpu_data[BANK_W-1:0];
            default: ;
          endcase
        end
        3'b010: if (!four_screen) mirror_q <= cpu_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cpu_addr[15:13])
      3'b100:  win_bank = swap_q ? bank_c[NB_W-1:0] : bank_a[NB_W-1:0];
      3'b101:  win_bank = swap_q ? bank_a[NB_W-1:0] : bank_b[NB_W-1:0];
      3'b110:  win_bank = swap_q ? bank_b[NB_W-1:0] : bank_c[NB_W-1:0];
      default: win_bank = '1;
    endcase
  end

  assign phys_addr    = {win_bank, cpu_addr[12:0]};
  assign mirror_horiz = mirror_q;

  // R8
  top_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b111) |-> (phys_addr[PRG_AW-1:13] == {NB_W{1'b1}}));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr || !cpu_addr[15]) |=> $stable({sel_idx, swap_q, bank_a, bank_b, bank_c, mirror_q}));

  // R5
  bad_index_chk: assert property (@(posedge clk) disable iff (rst)
    (in_space && wr_kind == 3'b001 && sel_idx != 4'd6 && sel_idx != 4'd7 && sel_idx != 4'd15)
    |=> $stable({bank_a, bank_b, bank_c}));

  // R10
  mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_space && wr_kind == 3'b010 && !four_screen) |=> (mirror_horiz == $past(cpu_data[0])));

  // R11
  strap_lock_chk: assert property (@(posedge clk) disable iff (rst)
    four_screen |=> $stable(mirror_horiz));
endmodule

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;
  localparam int AW = 17;
  localparam int NB = 1 << (AW - 13);

  logic clk = 1'b0, rst = 1'b1, cpu_wr = 1'b0, four_screen = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [AW-1:0] phys_addr;
  logic mirror_horiz;

  int errors = 0, checks = 0;
  int ma, mb, mc;
  bit mswap, mmir;

  prg_bank_mapper uut (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .four_screen(four_screen), .phys_addr(phys_addr), .mirror_horiz(mirror_horiz));

  always #4 clk = ~clk;

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_phys(input int addr);
    int w = (addr >> 13) & 3;
    int b;
    if (w == 3)      b = NB - 1;
    else if (!mswap) b = (w == 0) ? ma : (w == 1) ? mb : mc;
    else             b = (w == 0) ? mc : (w == 1) ? ma : mb;
    return ((b % NB) << 13) | (addr & 16'h1fff);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_data = 8'(d); cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic check_all(input string tag, input int ofs);
    for (int w = 0; w < 4; w++) begin
      int a = 16'h8000 | (w << 13) | (ofs & 16'h1fff);
      @(negedge clk); cpu_addr = 16'(a); #1;
      chk(tag, int'(phys_addr), exp_phys(a));
    end
    chk(tag, int'(mirror_horiz), int'(mmir));
  endtask

  task automatic set_reg(input int idx, input int v);
    wr(16'h8000, (int'(mswap) << 6) | idx);
    wr(16'h8001, v);
  endtask

  initial begin
    ma = NB - 4; mb = NB - 3; mc = NB - 2; mswap = 0; mmir = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_all("R1 reset map", 16'h0123);

    for (int s = 0; s < 2; s++) begin
      mswap = bit'(s);
      for (int v = 0; v < 32; v++) begin
        ma = v; mb = (v + 11) & 31; mc = (v * 7 + 3) & 31;
        set_reg(6, ma); set_reg(7, mb); set_reg(15, mc);
        check_all(s ? "R7 R9 R8 swap=1 sweep" : "R6 R9 R8 R4 swap=0 sweep", v * 263);
      end
    end

    for (int idx = 0; idx < 16; idx++) begin
      if (idx == 6 || idx == 7 || idx == 15) continue;
      set_reg(idx, 8'h0b);
      check_all("R5 ignored index", idx * 97);
    end

    mswap = 0;
    wr(16'h8000, 8'hb6);
    wr(16'h8001, 8'h05); ma = 5;
    check_all("R3 extra select bits", 16'h0444);

    wr(16'h6001, 8'h09);
    wr(16'h0000, 8'h47);
    @(negedge clk); cpu_addr = 16'h8001; cpu_data = 8'h0e; cpu_wr = 1'b0;
    @(posedge clk); #1;
    check_all("R2 out of range or no strobe", 16'h1abc);

    wr(16'ha000, 8'h01); mmir = 1;
    check_all("R10 mirror set", 16'h0010);
    wr(16'ha000, 8'hfe); mmir = 0;
    check_all("R10 mirror clear", 16'h0020);

    wr(16'ha001, 8'h01);
    wr(16'hc000, 8'h4f);
    wr(16'hc001, 8'h0c);
    wr(16'he000, 8'h4f);
    wr(16'he001, 8'h0d);
    wr(16'h8001, 8'h07); ma = 7;
    check_all("R12 foreign writes ignored", 16'h0777);

    four_screen = 1'b1;
    wr(16'ha000, 8'h01);
    check_all("R11 strap locks mirror", 16'h0030);
    four_screen = 1'b0;

    @(negedge clk);
    cpu_addr = 16'h8001; cpu_data = 8'h0a; cpu_wr = 1'b1; #1;
    chk("R13 old bank before edge", int'(phys_addr), exp_phys(16'h8001));
    @(posedge clk); #1; cpu_wr = 1'b0; ma = 10;
    chk("R13 new bank after edge", int'(phys_addr), exp_phys(16'h8001));

    @(negedge clk);
    rst = 1'b1; cpu_addr = 16'h8001; cpu_data = 8'h03; cpu_wr = 1'b1;
    @(posedge clk); #1; rst = 1'b0; cpu_wr = 1'b0;
    ma = NB - 4; mb = NB - 3; mc = NB - 2; mswap = 0; mmir = 0;
    check_all("R13 R1 reset beats write", 16'h0055);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule